// File: doc/BRIEF.md
# Reverse-Polarity Alarm Controller

This block watches a level-sensitive reverse-battery sense line. When it sees a reversal it waits a short confirmation window and samples the line again. It acts only if the reversal is still there. On a confirmed reversal it drops the charge enable. One cycle later it asks the charge-stage indicator logic to blank all seven stage LEDs. It then flashes the LED of the selected chemistry together with a buzzer, in equal on and off half-periods. The LED and buzzer are on together in one half and both off in the other. A separate fault indicator is never driven.

After each dark half-period the sense line is evaluated again. If the reversal has gone, the block waits a settle window and samples once more. If the reversal has come back, flashing resumes. Otherwise the steady chemistry LED is restored and the alarm ends. The charge enable stays low after the alarm until a higher-level controller sends a rearm pulse while the block is idle. Timing is counted in millisecond ticks supplied from outside.

The state machine has six states. `ST_WATCH` is idle with the steady LED. `ST_VERIFY` counts the confirmation window. `ST_CUTOFF` is one cycle in which the enable has already dropped and the stage LEDs are not yet blanked. `ST_FLASH` is the lit half-period and `ST_DARK` is the unlit half-period. `ST_SETTLE` is the exit recheck. The transitions are:
- watch→verify when a reversal is seen.
- verify→cutoff if the reversal is still present when the window ends; verify→watch if it is not.
- cutoff→flash on the next cycle.
- flash→dark when the half-period ends.
- dark→flash if still reversed when the half-period ends; dark→settle if not.
- settle→flash if reversed when the window ends; settle→watch if not.

Top module: `rev_alarm_ctrl`

## Requirements
- R1: After reset `chg_en` is 1, `buzzer`, `stage_blank` and `alarm_active` are 0, and `chem_led` shows the selected chemistry steadily.
- R2: A reversal that is gone when the VERIFY_MS-th tick after its detection arrives causes no alarm and leaves `chg_en` unchanged.
- R3: A reversal still present at that tick makes `chg_en` fall and `alarm_active` rise on the same clock edge. `stage_blank` rises exactly one clock later.
- R4: During the alarm, the selected chemistry LED and `buzzer` are on together for HALF_MS ticks. Then all chemistry LEDs and `buzzer` are off for HALF_MS ticks, and `stage_blank` stays 1 throughout.
- R5: A lit half-period always runs its full HALF_MS ticks even if the reversal ends inside it.
- R6: When a dark half-period ends without a reversal, a SETTLE_MS-tick recheck follows with all chemistry LEDs off. If the reversal is present at its end, a new lit half-period starts.
- R7: When the recheck ends without a reversal, `alarm_active`, `stage_blank` and `buzzer` return to 0 and the chemistry LED is lit steadily again.
- R8: `chg_en` stays 0 from the cut until a `rearm` pulse arrives while the block is idle. A `rearm` pulse during the alarm has no effect.
- R9: `chem_sel` codes 0, 1 and 2 light `chem_led` bits 0, 1 and 2 respectively. Code 3 lights none. At most one bit is ever set, and a code change takes effect on the next displayed LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| rev_sense | input | 1 | High while the battery is connected in reverse |
| chem_sel | input | 2 | Selected chemistry code |
| rearm | input | 1 | Pulse from the supervisor to re-enable charging |
| chg_en | output | 1 | Charge enable, high allows charging |
| buzzer | output | 1 | Buzzer drive, high sounds |
| chem_led | output | 3 | Chemistry LED drives, one-hot, high lit |
| stage_blank | output | 1 | Request to force all charge-stage LEDs off |
| alarm_active | output | 1 | High from confirmation until exit |

## Verification
The assertions take `ms_tick` to be a single-cycle strobe separated by idle cycles. They also take reset to be held for at least one clock before any checked behaviour. The lit-half length check relies on every tick during a lit half being counted exactly once. The bench produces the tick from a fixed divider of four clocks. It changes `rev_sense`, `chem_sel` and `rearm` only just after a falling clock edge, so no input is seen to change at a rising edge.

// File: rtl/rac_pkg.sv
package rac_pkg;

    typedef enum logic [2:0] {
        ST_WATCH   = 3'd0,
        ST_VERIFY  = 3'd1,
        ST_CUTOFF  = 3'd2,
        ST_FLASH   = 3'd3,
        ST_DARK    = 3'd4,
        ST_SETTLE  = 3'd5
    } rac_state_t;

endpackage

// File: rtl/rac_ms_timer.sv
module rac_ms_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] count_q;
    logic             at_last;

    // the tick that completes the programmed number of milliseconds
    assign at_last = (count_q == (limit - CNT_W'(1)));
    assign expire  = tick && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (tick) begin
            if (at_last) count_q <= '0;
            else         count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rac_fsm.sv
module rac_fsm
    import rac_pkg::*;
#(
    parameter int VERIFY_MS = 5,
    parameter int SETTLE_MS = 10,
    parameter int HALF_MS   = 500,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rev_sense,
    input  logic             rearm,
    input  logic             expire,
    output rac_state_t       state,
    output logic             timer_clr,
    output logic [CNT_W-1:0] timer_limit,
    output logic             chg_en
);

    localparam logic [CNT_W-1:0] LIM_VERIFY = CNT_W'(VERIFY_MS);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_MS);
    localparam logic [CNT_W-1:0] LIM_HALF   = CNT_W'(HALF_MS);

    rac_state_t state_q, state_nxt;
    logic       en_q;

    assign state = state_q;
    assign chg_en = en_q;

    // every state change restarts the millisecond count
    assign timer_clr = (state_nxt != state_q);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_WATCH:   if (rev_sense) state_nxt = ST_VERIFY;
            ST_VERIFY:  if (expire) state_nxt = rev_sense ? ST_CUTOFF : ST_WATCH;
            ST_CUTOFF:  state_nxt = ST_FLASH;
            ST_FLASH:   if (expire) state_nxt = ST_DARK;
            ST_DARK:    if (expire) state_nxt = rev_sense ? ST_FLASH : ST_SETTLE;
            ST_SETTLE:  if (expire) state_nxt = rev_sense ? ST_FLASH : ST_WATCH;
            default:    state_nxt = ST_WATCH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_WATCH, ST_VERIFY:          timer_limit = LIM_VERIFY;
            ST_SETTLE:                    timer_limit = LIM_SETTLE;
            ST_CUTOFF, ST_FLASH, ST_DARK: timer_limit = LIM_HALF;
            default:                      timer_limit = LIM_VERIFY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_nxt;
    end

    // enable: cleared on the confirming edge, set only by rearm while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (state_q == ST_VERIFY && state_nxt == ST_CUTOFF) begin
            en_q <= 1'b0;
        end else if (state_q == ST_WATCH && rearm) begin
            en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rac_led_decode.sv
module rac_led_decode #(
    parameter int NUM_CHEM = 3,
    parameter int CHEM_W   = 2
) (
    input  logic [CHEM_W-1:0]   code,
    input  logic                show,
    output logic [NUM_CHEM-1:0] leds
);

    for (genvar i = 0; i < NUM_CHEM; i++) begin : g_led
        assign leds[i] = show && (code == CHEM_W'(i));
    end

endmodule

// File: rtl/rev_alarm_ctrl.sv
module rev_alarm_ctrl
    import rac_pkg::*;
#(
    parameter int NUM_CHEM  = 3,
    parameter int CHEM_W    = 2,
    parameter int VERIFY_MS = 5,
    parameter int SETTLE_MS = 10,
    parameter int HALF_MS   = 500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic                rev_sense,
    input  logic [CHEM_W-1:0]   chem_sel,
    input  logic                rearm,
    output logic                chg_en,
    output logic                buzzer,
    output logic [NUM_CHEM-1:0] chem_led,
    output logic                stage_blank,
    output logic                alarm_active
);

    localparam int MAX_A = (VERIFY_MS > SETTLE_MS) ? VERIFY_MS : SETTLE_MS;
    localparam int MAX_MS = (HALF_MS > MAX_A) ? HALF_MS : MAX_A;
    localparam int CNT_W = $clog2(MAX_MS + 1);

    rac_state_t       state;
    logic             timer_clr;
    logic             expire;
    logic [CNT_W-1:0] timer_limit;
    logic             led_show;

    rac_fsm #(
        .VERIFY_MS (VERIFY_MS),
        .SETTLE_MS (SETTLE_MS),
        .HALF_MS   (HALF_MS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rev_sense   (rev_sense),
        .rearm       (rearm),
        .expire      (expire),
        .state       (state),
        .timer_clr   (timer_clr),
        .timer_limit (timer_limit),
        .chg_en      (chg_en)
    );

    rac_ms_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timer_clr),
        .tick   (ms_tick),
        .limit  (timer_limit),
        .expire (expire)
    );

    rac_led_decode #(
        .NUM_CHEM (NUM_CHEM),
        .CHEM_W   (CHEM_W)
    ) u_led (
        .code (chem_sel),
        .show (led_show),
        .leds (chem_led)
    );

    // Moore outputs from the state
    always_comb begin
        led_show     = 1'b1;
        buzzer       = 1'b0;
        stage_blank  = 1'b0;
        alarm_active = 1'b0;
        unique case (state)
            ST_WATCH, ST_VERIFY: begin
                led_show = 1'b1;
            end
            ST_CUTOFF: begin
                alarm_active = 1'b1;
            end
            ST_FLASH: begin
                buzzer       = 1'b1;
                stage_blank  = 1'b1;
                alarm_active = 1'b1;
            end
            ST_DARK, ST_SETTLE: begin
                led_show     = 1'b0;
                stage_blank  = 1'b1;
                alarm_active = 1'b1;
            end
            default: begin
                led_show = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rac_alarm_checks.sv
module rac_alarm_checks #(
    parameter int NUM_CHEM = 3,
    parameter int HALF_MS  = 500
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ms_tick,
    input logic                chg_en,
    input logic                buzzer,
    input logic [NUM_CHEM-1:0] chem_led,
    input logic                stage_blank,
    input logic                alarm_active
);

    int flash_ticks;

    always_ff @(posedge clk) begin
        if (!rst_n || !buzzer) flash_ticks <= 0;
        else if (ms_tick)      flash_ticks <= flash_ticks + 1;
    end

    a_r3_enable_drops_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_en) |-> alarm_active && !stage_blank);

    a_r3_blank_after_cut: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_blank) |-> !chg_en && $past(alarm_active));

    a_r8_enable_low_in_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_active |-> !chg_en);

    a_r4_buzzer_in_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |-> stage_blank && alarm_active);

    a_r7_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_active |-> !stage_blank && !buzzer);

    a_r9_single_led: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chem_led));

    a_r5_full_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buzzer) |-> flash_ticks == HALF_MS);

endmodule

bind rev_alarm_ctrl rac_alarm_checks #(
    .NUM_CHEM (NUM_CHEM),
    .HALF_MS  (HALF_MS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .chg_en       (chg_en),
    .buzzer       (buzzer),
    .chem_led     (chem_led),
    .stage_blank  (stage_blank),
    .alarm_active (alarm_active)
);

// File: tb/rev_alarm_ctrl_test.sv
`timescale 1ns/1ps
module rev_alarm_ctrl_test;

    localparam int VERIFY = 5;
    localparam int SETTLE = 10;
    localparam int HALF   = 500;
    localparam int DIV    = 4;

    localparam int P_IDLE = 0, P_CONF = 1, P_CUT = 2, P_ON = 3, P_OFF = 4, P_REC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       rev_sense = 1'b0;
    logic [1:0] chem_sel = 2'd1;
    logic       rearm = 1'b0;
    logic       chg_en, buzzer, stage_blank, alarm_active;
    logic [2:0] chem_led;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int div_cnt = 0;
    bit done = 1'b0;

    // reference model state
    int m_phase = P_IDLE;
    int m_left = 0;
    bit m_en = 1'b1;

    always #2 clk = ~clk;

    rev_alarm_ctrl #(
        .VERIFY_MS (VERIFY),
        .SETTLE_MS (SETTLE),
        .HALF_MS   (HALF)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .rev_sense    (rev_sense),
        .chem_sel     (chem_sel),
        .rearm        (rearm),
        .chg_en       (chg_en),
        .buzzer       (buzzer),
        .chem_led     (chem_led),
        .stage_blank  (stage_blank),
        .alarm_active (alarm_active)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // millisecond strobe, changed after falling edges
    always @(negedge clk) begin
        div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        ms_tick <= (div_cnt == DIV - 1);
    end

    // behavioural model: countdown of milliseconds left in the current phase
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_phase <= P_IDLE;
            m_left  <= 0;
            m_en    <= 1'b1;
        end else begin
            case (m_phase)
                P_IDLE: begin
                    if (rearm) m_en <= 1'b1;
                    if (rev_sense) begin m_phase <= P_CONF; m_left <= VERIFY; end
                end
                P_CONF: if (ms_tick) begin
                    if (m_left == 1) begin
                        if (rev_sense) begin m_phase <= P_CUT; m_en <= 1'b0; end
                        else m_phase <= P_IDLE;
                    end else m_left <= m_left - 1;
                end
                P_CUT: begin m_phase <= P_ON; m_left <= HALF; end
                P_ON: if (ms_tick) begin
                    if (m_left == 1) begin m_phase <= P_OFF; m_left <= HALF; end
                    else m_left <= m_left - 1;
                end
                P_OFF: if (ms_tick) begin
                    if (m_left == 1) begin
                        if (rev_sense) begin m_phase <= P_ON; m_left <= HALF; end
                        else begin m_phase <= P_REC; m_left <= SETTLE; end
                    end else m_left <= m_left - 1;
                end
                default: if (ms_tick) begin
                    if (m_left == 1) begin
                        if (rev_sense) begin m_phase <= P_ON; m_left <= HALF; end
                        else m_phase <= P_IDLE;
                    end else m_left <= m_left - 1;
                end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_led;
            exp_led = 0;
            if ((m_phase == P_IDLE || m_phase == P_CONF || m_phase == P_CUT || m_phase == P_ON)
                && chem_sel != 2'd3)
                exp_led = 1 << chem_sel;
            check("R8 chg_en", int'(chg_en), int'(m_en));
            check("R4 buzzer", int'(buzzer), int'(m_phase == P_ON));
            check("R9 chem_led", int'(chem_led), exp_led);
            check("R3 stage_blank", int'(stage_blank),
                  int'(m_phase == P_ON || m_phase == P_OFF || m_phase == P_REC));
            check("R7 alarm_active", int'(alarm_active),
                  int'(m_phase != P_IDLE && m_phase != P_CONF));
        end
    end

    task automatic wait_ms(input int n);
        repeat (n * DIV) @(negedge clk);
        #1;
    endtask

    task automatic at_next_neg;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_rearm;
        at_next_neg();
        rearm = 1'b1;
        at_next_neg();
        rearm = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        at_next_neg();
        // R1 reset state
        check("R1 chg_en", int'(chg_en), 1);
        check("R1 led", int'(chem_led), 3'b010);
        check("R1 alarm", int'(alarm_active | buzzer | stage_blank), 0);

        // R2 short glitch
        rev_sense = 1'b1;
        wait_ms(2);
        rev_sense = 1'b0;
        wait_ms(8);
        check("R2 no alarm", int'(alarm_active), 0);
        check("R2 chg_en kept", int'(chg_en), 1);

        // R3 confirmed reversal
        rev_sense = 1'b1;
        wait (m_phase == P_CUT);
        @(negedge clk);
        check("R3 cut enable", int'(chg_en), 0);
        check("R3 cut not blanked", int'(stage_blank), 0);
        check("R3 cut alarm", int'(alarm_active), 1);
        @(negedge clk);
        check("R3 blank next", int'(stage_blank), 1);

        // R4 blink halves
        wait_ms(250);
        check("R4 buzzer lit", int'(buzzer), 1);
        check("R4 led lit", int'(chem_led), 3'b010);
        wait (m_phase == P_OFF);
        @(negedge clk);
        check("R4 dark buzzer", int'(buzzer), 0);
        check("R4 dark led", int'(chem_led), 0);
        #1 chem_sel = 2'd2;
        wait (m_phase == P_ON);
        @(negedge clk);
        check("R9 new chemistry", int'(chem_led), 3'b100);

        // R5 reversal ends mid half
        wait_ms(100);
        rev_sense = 1'b0;
        wait_ms(10);
        check("R5 still lit", int'(buzzer), 1);
        pulse_rearm();
        at_next_neg();
        check("R8 rearm ignored", int'(chg_en), 0);

        // R6 recheck and resume
        wait (m_phase == P_REC);
        @(negedge clk);
        check("R6 recheck alarm", int'(alarm_active), 1);
        check("R6 recheck led", int'(chem_led), 0);
        #1;
        wait_ms(3);
        rev_sense = 1'b1;
        wait (m_phase == P_ON);
        @(negedge clk);
        check("R6 resumed", int'(buzzer), 1);
        #1 rev_sense = 1'b0;

        // R7 exit
        wait (m_phase == P_REC);
        wait (m_phase == P_IDLE);
        @(negedge clk);
        check("R7 exit alarm", int'(alarm_active), 0);
        check("R7 exit blank", int'(stage_blank), 0);
        check("R7 steady led", int'(chem_led), 3'b100);
        check("R8 still off", int'(chg_en), 0);
        #1;
        wait_ms(5);
        check("R8 off later", int'(chg_en), 0);
        pulse_rearm();
        at_next_neg();
        check("R8 rearmed", int'(chg_en), 1);

        // R9 codes
        chem_sel = 2'd3;
        at_next_neg();
        check("R9 code 3", int'(chem_led), 0);
        chem_sel = 2'd0;
        at_next_neg();
        check("R9 code 0", int'(chem_led), 3'b001);

        done = 1'b1;
        finish_run();
    end

endmodule